// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block produces one generated clock from a bank of candidate input clocks. A 4-bit select code picks the source clock. The chosen clock is divided by an integer taken from a separate divisor input, and the result drives `clk_o`. One 32-bit control word carries every setting: the source code, an asynchronous stop, a clean run/stop bit, a duty-correction bit for odd divisors, a 2-bit start delay and a phase-nudge toggle.

The bit positions in the control word are part of the interface, because the register that writes this word decodes the same fields: source select at [8:5], kill at [10], enable at [11], duty correction at [12], start delay at [17:16] and nudge at [20]. All other bits are ignored. The block carries no data stream, so every pin is a plain control or clock signal and there is no valid/ready handshake. The design assumes that software changes the source code only while the generator is stopped. A switch of source while the generator runs may glitch the output, and that is allowed.

Top module: `clkgen_out`

## Requirements
- R1: Source codes 0 to 10 select `src_clk_i[code]`. Codes 11 to 15 select no clock, and the output then stays low even when enable is set.
- R2: While kill (bit 10) is 1, `clk_o` is 0 at once, with no clock edge needed, and stays 0 until kill returns to 0.
- R3: For a divisor N of 2 or more, the output period is N source periods. The output rises on a source rising edge and stays high for floor(N/2) source periods when N is even or when duty correction is off.
- R4: With duty correction (bit 12) set and an odd N of 3 or more, the high time is N/2 source periods. The output falls on a source falling edge.
- R5: A divisor of 0 or 1 passes the source clock straight through while enabled. The gate opens and closes only while the source is low, so every pulse is whole.
- R6: After enable (bit 11) is cleared, the output finishes the current period with full high and low times and then stays low.
- R7: With start delay P (bits 17:16), the first output rising edge comes on the (P+2)th source rising edge after enable is written. The first of those edges samples enable. The delay is captured only while the generator has not yet seen enable.
- R8: Each toggle of the nudge bit (bit 20), 0 to 1 or 1 to 0, makes exactly one output period one source period longer. The periods after it are back to normal.
- R9: Reset clears all internal state and the output is low.
- R10: The divisor is captured only while the generator is stopped. A change while it runs leaves the period alone until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_i | input | 1 | Asynchronous reset, active high |
| src_clk_i | input | NUM_SRC (11) | Candidate source clocks, one per select code |
| ctrl_i | input | 32 | Control word with the fields listed above |
| divisor_i | input | DIV_W (8) | Integer divisor; 0 and 1 mean pass-through |
| clk_o | output | 1 | Generated clock |

## Verification
The bench measures rising-to-falling and rising-to-rising times on the output in nanoseconds against a 10 ns source. A design that puts the odd-divisor falling edge on the wrong source edge shows a high time off by half a source period. A design that stops on the next source edge instead of at the period boundary cuts the last high pulse short. The nudge test compares two successive periods. A design that drops or doubles the stretch, or treats only rising toggles as a nudge, then shows 40/40 or 60/40 ns instead of 50/40 ns. The start-delay test times the first edge after enable for two delay values. A design that captures the delay at the wrong moment, or counts the pipeline off by one, misses the 15 ns and 45 ns marks. The bench also switches to an undefined source code, asserts kill in the middle of a high pulse, and changes the divisor while the generator runs.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int SEL_W  = 4;
  localparam int PH_W   = 2;
  localparam int SEL_LO = 5;
  localparam int KILL_B = 10;
  localparam int EN_B   = 11;
  localparam int DC_B   = 12;
  localparam int PH_LO  = 16;
  localparam int NUD_B  = 20;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             kill;
    logic             run;
    logic             duty_fix;
    logic [PH_W-1:0]  delay;
    logic             nudge;
  } gen_ctrl_t;

  function automatic gen_ctrl_t unpack_ctrl(input logic [31:0] w);
    gen_ctrl_t c;
    c.sel      = w[SEL_LO +: SEL_W];
    c.kill     = w[KILL_B];
    c.run      = w[EN_B];
    c.duty_fix = w[DC_B];
    c.delay    = w[PH_LO +: PH_W];
    c.nudge    = w[NUD_B];
    return c;
  endfunction
endpackage

// File: rtl/clkgen_src_mux.sv
module clkgen_src_mux #(
  parameter int N  = 11,
  parameter int SW = 4
) (
  input  logic [N-1:0]  src_i,
  input  logic [SW-1:0] sel_i,
  output logic          clk_o
);
  // codes beyond N-1 leave the output tied low
  always_comb begin
    clk_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SW'(i)) clk_o = src_i[i];
    end
  end
endmodule

// File: rtl/clkgen_start_delay.sv
module clkgen_start_delay #(
  parameter int PH_W = 2
) (
  input  logic            clk_i,
  input  logic            arst_i,
  input  logic            run_i,
  input  logic [PH_W-1:0] delay_i,
  input  logic            nudge_i,
  output logic            run_o,
  output logic            nudge_edge_o
);
  localparam int DEPTH = 1 << PH_W;

  logic [DEPTH-1:0] stage_q;
  logic [PH_W-1:0]  delay_q;
  logic             nud_a_q, nud_b_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      stage_q <= '0;
      delay_q <= '0;
      nud_a_q <= 1'b0;
      nud_b_q <= 1'b0;
    end else begin
      stage_q <= {stage_q[DEPTH-2:0], run_i};
      // delay is frozen once the first stage has seen enable
      if (!stage_q[0]) delay_q <= delay_i;
      nud_a_q <= nudge_i;
      nud_b_q <= nud_a_q;
    end
  end

  assign run_o        = stage_q[delay_q];
  assign nudge_edge_o = nud_a_q ^ nud_b_q;

  // R7: selected stage only asserts after the first stage saw enable
  assert_delay_order_R7: assert property (@(posedge clk_i) disable iff (arst_i)
    $rose(run_o) |-> $past(stage_q[0]) || stage_q[0]);
endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             arst_i,
  input  logic             run_i,
  input  logic             nudge_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             hi_pos_o,
  output logic             hi_neg_o,
  output logic             pass_gate_o,
  output logic             bypass_o,
  output logic             odd_o
);
  logic             active_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             hi_pos_q, hi_neg_q, gate_q;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_inc;
  logic             bypass;

  assign half    = div_q >> 1;
  assign cnt_inc = cnt_q + 1'b1;
  assign bypass  = (div_q <= DIV_W'(1));

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      div_q    <= '0;
      hi_pos_q <= 1'b0;
    end else if (!active_q) begin
      div_q <= div_i;
      cnt_q <= '0;
      if (run_i && !bypass) begin
        active_q <= 1'b1;
        hi_pos_q <= 1'b1;
      end else begin
        hi_pos_q <= 1'b0;
      end
    end else if (nudge_i) begin
      // swallow one count: period grows by one source cycle
      cnt_q    <= cnt_q;
      hi_pos_q <= hi_pos_q;
    end else if (cnt_q == div_q - 1'b1) begin
      cnt_q <= '0;
      if (run_i) begin
        hi_pos_q <= 1'b1;
      end else begin
        active_q <= 1'b0;
        hi_pos_q <= 1'b0;
      end
    end else begin
      cnt_q    <= cnt_inc;
      hi_pos_q <= (cnt_inc < half);
    end
  end

  always_ff @(negedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      hi_neg_q <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      hi_neg_q <= hi_pos_q;
      gate_q   <= run_i && bypass;
    end
  end

  assign hi_pos_o    = hi_pos_q;
  assign hi_neg_o    = hi_neg_q;
  assign pass_gate_o = gate_q;
  assign bypass_o    = bypass;
  assign odd_o       = div_q[0];

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (arst_i)
    active_q |-> cnt_q < div_q);
  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (arst_i)
    !active_q |-> !hi_pos_q);
  assert_stop_at_end_R6: assert property (@(posedge clk_i) disable iff (arst_i)
    $fell(active_q) |-> $past(cnt_q) == $past(div_q) - 1'b1);
  assert_nudge_hold_R8: assert property (@(posedge clk_i) disable iff (arst_i)
    active_q && nudge_i |=> cnt_q == $past(cnt_q));
  assert_div_frozen_R10: assert property (@(posedge clk_i) disable iff (arst_i)
    active_q && $past(active_q) |-> $stable(div_q));
endmodule

// File: rtl/clkgen_out.sv
module clkgen_out
  import clkgen_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int DIV_W   = 8
) (
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic [31:0]        ctrl_i,
  input  logic [DIV_W-1:0]   divisor_i,
  output logic               clk_o
);
  gen_ctrl_t cfg;
  logic      sel_clk;
  logic      arst;
  logic      run_dly, nudge_edge;
  logic      hi_pos, hi_neg, pass_gate, bypass, odd_div;
  logic      unused_ctrl;

  assign cfg  = unpack_ctrl(ctrl_i);
  assign arst = rst_i | cfg.kill;
  assign unused_ctrl = ^{ctrl_i[31:21], ctrl_i[19:18], ctrl_i[15:13],
                         ctrl_i[9], ctrl_i[4:0]};

  clkgen_src_mux #(.N(NUM_SRC), .SW(SEL_W)) u_mux (
    .src_i (src_clk_i),
    .sel_i (cfg.sel),
    .clk_o (sel_clk)
  );

  clkgen_start_delay #(.PH_W(PH_W)) u_delay (
    .clk_i        (sel_clk),
    .arst_i       (arst),
    .run_i        (cfg.run),
    .delay_i      (cfg.delay),
    .nudge_i      (cfg.nudge),
    .run_o        (run_dly),
    .nudge_edge_o (nudge_edge)
  );

  clkgen_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i       (sel_clk),
    .arst_i      (arst),
    .run_i       (run_dly),
    .nudge_i     (nudge_edge),
    .div_i       (divisor_i),
    .hi_pos_o    (hi_pos),
    .hi_neg_o    (hi_neg),
    .pass_gate_o (pass_gate),
    .bypass_o    (bypass),
    .odd_o       (odd_div)
  );

  always_comb begin
    if (bypass)
      clk_o = sel_clk & pass_gate;
    else if (cfg.duty_fix && odd_div)
      clk_o = hi_pos | hi_neg;   // fall stretched to the next source fall
    else
      clk_o = hi_pos;
  end

  assert_kill_low_R2: assert property (@(posedge sel_clk) disable iff (rst_i)
    cfg.kill |-> !clk_o);
  assert_gate_idle_R5: assert property (@(posedge sel_clk) disable iff (arst)
    !bypass |-> !pass_gate);
endmodule

// File: tb/tb_clkgen_out.sv
`timescale 1ns/1ps
module tb_clkgen_out;
  localparam int NS = 11;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          s1 = 1'b0;
  logic          s2 = 1'b0;
  logic          rst;
  logic [31:0]   ctrl;
  logic [DW-1:0] divisor;
  logic          clk_o;
  logic [NS-1:0] srcs;
  logic          nud_bit;
  int            checks = 0;
  int            failures = 0;

  always #5 clk = ~clk;
  always #7 s1 = ~s1;
  always #8 s2 = ~s2;
  assign srcs = {8'b0, s2, s1, clk};

  clkgen_out #(.NUM_SRC(NS), .DIV_W(DW)) dut (
    .rst_i     (rst),
    .src_clk_i (srcs),
    .ctrl_i    (ctrl),
    .divisor_i (divisor),
    .clk_o     (clk_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int src, input bit en, input bit dc,
                                       input int ph, input bit kill);
    logic [31:0] w = '0;
    w[8:5]   = src[3:0];
    w[10]    = kill;
    w[11]    = en;
    w[12]    = dc;
    w[17:16] = ph[1:0];
    w[20]    = nud_bit;
    return w;
  endfunction

  task automatic apply(input int src, input bit en, input bit dc, input int ph);
    @(negedge clk);
    ctrl = word(src, en, dc, ph, 1'b0);
  endtask

  task automatic halt();
    apply(0, 1'b0, 1'b0, 0);
    repeat (40) @(posedge clk);
  endtask

  task automatic measure(output longint hi, output longint per);
    longint t0, t1;
    @(posedge clk_o); t0 = $time;
    @(negedge clk_o); t1 = $time;
    @(posedge clk_o);
    hi = t1 - t0;
    per = $time - t0;
  endtask

  task automatic t_reset();
    rst = 1'b1; ctrl = '0; divisor = 8'd4; nud_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R9 low in reset", clk_o, 0);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    #1 chk("R9 low after reset", clk_o, 0);
  endtask

  task automatic t_even();
    longint hi, per;
    divisor = 8'd4; apply(0, 1'b1, 1'b0, 0);
    measure(hi, per);
    chk("R3 div4 period", per, 40); chk("R3 div4 high", hi, 20);
    halt();
    divisor = 8'd2; apply(0, 1'b1, 1'b0, 0);
    measure(hi, per);
    chk("R3 div2 period", per, 20); chk("R3 div2 high", hi, 10);
    halt();
  endtask

  task automatic t_odd();
    longint hi, per;
    divisor = 8'd5; apply(0, 1'b1, 1'b0, 0);
    measure(hi, per);
    chk("R3 div5 plain period", per, 50); chk("R3 div5 plain high", hi, 20);
    halt();
    apply(0, 1'b1, 1'b1, 0);
    measure(hi, per);
    chk("R4 div5 corrected period", per, 50); chk("R4 div5 corrected high", hi, 25);
    halt();
    divisor = 8'd3; apply(0, 1'b1, 1'b1, 0);
    measure(hi, per);
    chk("R4 div3 corrected high", hi, 15);
    halt();
  endtask

  task automatic t_bypass();
    longint hi, per;
    divisor = 8'd0; apply(0, 1'b1, 1'b0, 0);
    measure(hi, per);
    chk("R5 div0 period", per, 10); chk("R5 div0 high", hi, 5);
    halt();
    divisor = 8'd1; apply(0, 1'b1, 1'b0, 0);
    measure(hi, per);
    chk("R5 div1 period", per, 10);
    halt();
    #1 chk("R5 gate closed after stop", clk_o, 0);
  endtask

  task automatic t_source();
    longint hi, per;
    int highs = 0;
    divisor = 8'd2; apply(2, 1'b0, 1'b0, 0); apply(2, 1'b1, 1'b0, 0);
    measure(hi, per);
    chk("R1 src2 period", per, 32); chk("R1 src2 high", hi, 16);
    apply(2, 1'b0, 1'b0, 0); repeat (40) @(posedge clk);
    divisor = 8'd3; apply(1, 1'b0, 1'b1, 0); apply(1, 1'b1, 1'b1, 0);
    measure(hi, per);
    chk("R1 src1 period", per, 42); chk("R1 src1 high", hi, 21);
    apply(1, 1'b0, 1'b1, 0); repeat (40) @(posedge clk);
    apply(13, 1'b0, 1'b0, 0); apply(13, 1'b1, 1'b0, 0);
    for (int i = 0; i < 60; i++) begin
      #3; if (clk_o) highs++;
    end
    chk("R1 undefined code stays low", highs, 0);
    apply(13, 1'b0, 1'b0, 0);
    apply(0, 1'b0, 1'b0, 0);
    repeat (10) @(posedge clk);
  endtask

  task automatic t_delay();
    longint t0;
    divisor = 8'd4;
    @(negedge clk); ctrl = word(0, 1'b1, 1'b0, 0, 1'b0); t0 = $time;
    @(posedge clk_o);
    chk("R7 delay0 first edge", $time - t0, 15);
    halt();
    @(negedge clk); ctrl = word(0, 1'b1, 1'b0, 3, 1'b0); t0 = $time;
    @(posedge clk_o);
    chk("R7 delay3 first edge", $time - t0, 45);
    apply(0, 1'b0, 1'b0, 3); repeat (40) @(posedge clk);
  endtask

  task automatic t_nudge();
    longint ta, tb, tc;
    divisor = 8'd4; apply(0, 1'b1, 1'b0, 0);
    @(posedge clk_o); ta = $time;
    @(negedge clk); nud_bit = ~nud_bit; ctrl = word(0, 1'b1, 1'b0, 0, 1'b0);
    @(posedge clk_o); tb = $time;
    @(posedge clk_o); tc = $time;
    chk("R8 rising toggle stretched period", tb - ta, 50);
    chk("R8 next period normal", tc - tb, 40);
    @(posedge clk_o); ta = $time;
    @(negedge clk); nud_bit = ~nud_bit; ctrl = word(0, 1'b1, 1'b0, 0, 1'b0);
    @(posedge clk_o); tb = $time;
    chk("R8 falling toggle stretched period", tb - ta, 50);
    halt();
  endtask

  task automatic t_clean_stop();
    longint t0;
    int highs = 0;
    divisor = 8'd8; apply(0, 1'b1, 1'b0, 0);
    @(posedge clk_o); t0 = $time;
    apply(0, 1'b0, 1'b0, 0);
    @(negedge clk_o);
    chk("R6 last high pulse whole", $time - t0, 40);
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1 if (clk_o) highs++;
    end
    chk("R6 low after stop", highs, 0);
  endtask

  task automatic t_kill();
    int highs = 0;
    divisor = 8'd4; apply(0, 1'b1, 1'b0, 0);
    @(posedge clk_o); #2;
    ctrl = word(0, 1'b1, 1'b0, 0, 1'b1);
    #1 chk("R2 kill drops output at once", clk_o, 0);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1 if (clk_o) highs++;
    end
    chk("R2 output held low under kill", highs, 0);
    apply(0, 1'b0, 1'b0, 0);
    repeat (10) @(posedge clk);
  endtask

  task automatic t_div_live();
    longint hi, per;
    divisor = 8'd4; apply(0, 1'b1, 1'b0, 0);
    @(posedge clk_o);
    @(negedge clk); divisor = 8'd6;
    measure(hi, per);
    chk("R10 divisor change ignored while running", per, 40);
    halt();
    apply(0, 1'b1, 1'b0, 0);
    measure(hi, per);
    chk("R10 new divisor after restart", per, 60);
    halt();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_even();
    t_odd();
    t_bypass();
    t_source();
    t_delay();
    t_nudge();
    t_clean_stop();
    t_kill();
    t_div_live();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule